// File: doc/BRIEF.md
# Byte-String Palindrome Scanner

This block decides whether a byte string stored in a 64K-byte single-port synchronous memory is a palindrome. The caller gives it a 16-bit start address, a 16-bit length and a ready level. A rising edge of ready starts a check. Two address cursors then walk inward from the two ends of the string. One cursor counts up from the first byte and the other counts down from the last byte.

A multiplexer chooses which cursor drives the single memory address bus. For each pair, the front byte is read first and parked in a holding register. The back byte is read next and compared with it. The scan stops at the first unequal pair, or when the cursors meet or cross. The block then raises a done flag together with a result flag.

The memory has one cycle of read latency. Each pair therefore costs three cycles: front read, back read, compare. For odd lengths the middle byte is never fetched. The result comes from pairwise comparison only, so no checksum shortcut is involved.

Top module: `pal_scan`

## Requirements
- R1: While reset is applied, `done`, `is_pal` and `mem_re` are all 0.
- R2: A check starts only on a rising edge of `go` seen while idle or finished. A held-high `go`, or a new rising edge while a check is running, starts nothing.
- R3: A length of 0 or 1 raises `done=1`, `is_pal=1` at the start edge itself, with no memory read.
- R4: For pair j (counting from 0), the block reads `base+j` and then `base+len-1-j`. Each read is a single cycle with `mem_re=1`. No read falls outside the string.
- R5: Counting the start edge as 1, `done` is observed high after 1+3·P clock edges, where P is the number of pairs compared.
- R6: For a palindrome of length 2 or more, P equals len/2 (integer division) and `is_pal=1`. For odd lengths the middle byte is never read.
- R7: At the first pair j whose bytes differ, the scan stops with P=j+1 and `is_pal=0`. This holds even when the string's byte sum equals that of its reverse.
- R8: `done` is 0 while a check is running. Once `done` is 1, it and `is_pal` stay unchanged until the next accepted start.
- R9: `is_pal` is 0 whenever `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Ready level; its rising edge starts a check |
| base_addr | input | 16 | Address of the first string byte |
| str_len | input | 16 | String length in bytes |
| mem_addr | output | 16 | Memory address (front or back cursor) |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| done | output | 1 | Check complete |
| is_pal | output | 1 | String is a palindrome (meaningful with done) |

## Verification
The bench sweeps lengths 0 to 13 and plants a mismatch at every pair position, plus a fully symmetric case. This exposes an off-by-one in the meeting test, which would compare one pair too many or too few and show up in the read count and latency. A flipped inner pair catches a design that stops early or ignores late mismatches. A string with equal forward and reverse byte sums catches any sum-based shortcut. Strings that end at 0xFFFF, and strings of length 0 or 1, target cursor wraparound and any read issued where none should occur. A rising edge of `go` injected mid-scan, and `go` held high after completion, show whether the block restarts when it must not.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RDF  = 3'd1,
    ST_RDB  = 3'd2,
    ST_CMP  = 3'd3,
    ST_DONE = 3'd4
  } scan_st_e;

  typedef enum logic {
    SEL_FRONT = 1'b0,
    SEL_BACK  = 1'b1
  } addr_sel_e;
endpackage

// File: rtl/pal_cursors.sv
module pal_cursors
  import pal_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  addr_sel_e     sel,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] addr,
  output logic          meet_next
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] front_q, back_q;

  function automatic logic [AW-1:0] tail_of(input logic [AW-1:0] b, input logic [LW-1:0] n);
    return b + AW'(n) - ONE;
  endfunction

  function automatic logic cursors_meet(input logic [AW-1:0] f, input logic [AW-1:0] b);
    return (f + ONE) >= (b - ONE);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front_q <= '0;
      back_q  <= '0;
    end else if (load) begin
      front_q <= base;
      back_q  <= tail_of(base, len);
    end else if (step) begin
      front_q <= front_q + ONE;
      back_q  <= back_q - ONE;
    end
  end

  assign addr      = (sel == SEL_BACK) ? back_q : front_q;
  assign meet_next = cursors_meet(front_q, back_q);

  // R4
  cursor_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (front_q < back_q));
endmodule

// File: rtl/pal_hold_cmp.sv
module pal_hold_cmp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] rdata,
  output logic          bytes_eq
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= rdata;
  end

  assign bytes_eq = (hold_q == rdata);
endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [LW-1:0] len,
  input  logic          meet_next,
  input  logic          bytes_eq,
  output logic          load,
  output logic          step,
  output addr_sel_e     sel,
  output logic          mem_re,
  output logic          capture,
  output logic          done,
  output logic          is_pal
);
  scan_st_e state_q, state_d;
  logic go_q, done_q, done_d, pal_q, pal_d;
  logic start, start_ok, cmp_fire, mismatch;

  function automatic logic too_short(input logic [LW-1:0] n);
    return n <= LW'(1);
  endfunction

  assign start    = go && !go_q;
  assign start_ok = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign cmp_fire = (state_q == ST_CMP);
  assign mismatch = cmp_fire && !bytes_eq;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    pal_d   = pal_q;
    load    = 1'b0;
    step    = 1'b0;
    sel     = SEL_FRONT;
    mem_re  = 1'b0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_ok) begin
          if (too_short(len)) begin
            state_d = ST_DONE;
            done_d  = 1'b1;
            pal_d   = 1'b1;
          end else begin
            state_d = ST_RDF;
            done_d  = 1'b0;
            pal_d   = 1'b0;
            load    = 1'b1;
          end
        end
      end
      ST_RDF: begin
        mem_re  = 1'b1;
        state_d = ST_RDB;
      end
      ST_RDB: begin
        mem_re  = 1'b1;
        sel     = SEL_BACK;
        capture = 1'b1;
        state_d = ST_CMP;
      end
      ST_CMP: begin
        if (mismatch) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
          pal_d   = 1'b0;
        end else begin
          step = 1'b1;
          if (meet_next) begin
            state_d = ST_DONE;
            done_d  = 1'b1;
            pal_d   = 1'b1;
          end else begin
            state_d = ST_RDF;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
      pal_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= go;
      done_q  <= done_d;
      pal_q   <= pal_d;
    end
  end

  assign done   = done_q;
  assign is_pal = pal_q;

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDF || state_q == ST_RDB || state_q == ST_CMP) |-> !done_q);
  // R9
  pal_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> !pal_q);
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> (done_q && $stable(pal_q)));
  // R3
  short_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && too_short(len)) |=> (done_q && pal_q));
  // R7
  mismatch_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> (done_q && !pal_q));
  // R5
  front_then_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDF) |=> (state_q == ST_RDB));
  // R5
  back_then_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDB) |=> (state_q == ST_CMP));
  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state_q == ST_RDB)) |=> (state_q == ST_CMP));
endmodule

// File: rtl/pal_scan.sv
module pal_scan
  import pal_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] str_len,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          is_pal
);
  logic      load, step, capture, meet_next, bytes_eq;
  addr_sel_e sel;

  pal_ctrl #(.LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .len(str_len),
    .meet_next(meet_next), .bytes_eq(bytes_eq),
    .load(load), .step(step), .sel(sel), .mem_re(mem_re),
    .capture(capture), .done(done), .is_pal(is_pal)
  );

  pal_cursors #(.AW(AW), .LW(LW)) u_cur (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .sel(sel),
    .base(base_addr), .len(str_len), .addr(mem_addr), .meet_next(meet_next)
  );

  pal_hold_cmp #(.DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .capture(capture), .rdata(mem_rdata),
    .bytes_eq(bytes_eq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rst_n |-> (!done && !is_pal && !mem_re)));
  // R4
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !done);
endmodule

// File: tb/pal_scan_test.sv
module pal_scan_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [15:0] base_addr = '0;
  logic [15:0] str_len = '0;
  logic [15:0] mem_addr;
  logic        mem_re;
  logic [7:0]  mem_rdata;
  logic        done, is_pal;

  logic [7:0]  mem [0:255];
  logic [15:0] rd_log [0:255];
  int          rd_n = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;

  always #(CLK_P/2) clk = ~clk;

  pal_scan uut (
    .clk(clk), .rst_n(rst_n), .go(go), .base_addr(base_addr), .str_len(str_len),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .done(done), .is_pal(is_pal)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[7:0]];
    if (mem_re) begin
      rd_log[rd_n[7:0]] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int base, input int len, input int seed, input int bad_pair);
    for (int i = 0; i < len; i++) begin
      int m = (i < len - 1 - i) ? i : len - 1 - i;
      mem[(base + i) & 255] = 8'((seed * 7 + m * 13 + 1) & 255);
    end
    if (bad_pair >= 0)
      mem[(base + len - 1 - bad_pair) & 255] = mem[(base + len - 1 - bad_pair) & 255] ^ 8'h5A;
  endtask

  task automatic run(input int base, input int len, input bit poke);
    int pairs = len / 2;
    int exp_p = pairs;
    bit exp_pal = 1;
    int exp_lat, lat, r0;
    for (int j = 0; j < pairs; j++) begin
      if (exp_pal && mem[(base + j) & 255] != mem[(base + len - 1 - j) & 255]) begin
        exp_pal = 0;
        exp_p = j + 1;
      end
    end
    exp_lat = (len <= 1) ? 1 : 1 + 3 * exp_p;
    @(negedge clk);
    base_addr = 16'(base);
    str_len = 16'(len);
    go = 1'b1;
    r0 = rd_n;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 2) go = 1'b0;
      if (poke && lat == 3) go = 1'b1;
      // R9
      if (!done) chk(!is_pal, "R9 is_pal while busy", is_pal, 0);
    end while (!done && lat < 400);
    // R5 R3
    chk(lat == exp_lat, (len <= 1) ? "R3 short latency" : "R5 latency", lat, exp_lat);
    // R6 R7
    chk(is_pal == exp_pal, exp_pal ? "R6 palindrome result" : "R7 mismatch result", is_pal, exp_pal);
    // R4
    chk((rd_n - r0) == 2 * ((len <= 1) ? 0 : exp_p), "R4 read count", rd_n - r0, 2 * exp_p);
    for (int k = 0; k < rd_n - r0 && k < 32; k++) begin
      int ea = (k % 2 == 0) ? base + k / 2 : base + len - 1 - k / 2;
      chk(rd_log[(r0 + k) & 255] == 16'(ea), "R4 read address", rd_log[(r0 + k) & 255], ea);
    end
    // R2 R8: go held high, nothing restarts, result stays
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk(done && is_pal == exp_pal && !mem_re, "R2 R8 hold after done", {done, is_pal}, {1'b1, exp_pal});
    end
    go = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3);
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !is_pal && !mem_re, "R1 reset outputs", {done, is_pal, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !is_pal, "R1 idle after reset", {done, is_pal}, 0);

    for (int len = 0; len <= 13; len++) begin
      for (int bp = -1; bp < len / 2; bp++) begin
        int base = 256 * len + 16 + (bp + 1) * 3;
        fill(base, len, len + bp, bp);
        run(base, len, 1'b0);
      end
    end
    // R6 string ending at top of memory
    fill(16'hFFF0, 16, 5, -1);
    run(16'hFFF0, 16, 1'b0);
    fill(16'hFFF0, 16, 6, 7);
    run(16'hFFF0, 16, 1'b0);
    // R7 same byte sum forwards and backwards
    mem[8'h40] = 8'hFF; mem[8'h41] = 8'hFF; mem[8'h42] = 8'hAA; mem[8'h43] = 8'hAA;
    run(16'h0040, 4, 1'b0);
    // R2 rising edge of go in mid-scan is ignored
    fill(16'h3000, 9, 2, -1);
    run(16'h3000, 9, 1'b1);
    fill(16'h3100, 10, 3, 4);
    run(16'h3100, 10, 1'b1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule